// File: doc/BRIEF.md
# Oversampled Shift-Window Serial Receiver

This block turns an asynchronous serial line carrying 8-bit frames with no parity and one stop bit into parallel bytes. It samples the line five times per bit period. Every sample is shifted into a window register that is one frame long. The newest sample enters at the top and the oldest sits at bit 0. There is no per-bit state machine. When the four oldest samples in the window are all low, a start bit has been found. The eight data bits and the stop bit are then read at the same moment from fixed positions in the window.

If the stop sample is high, the byte is presented on the data output with a one-cycle valid strobe. The byte stays there until the next good frame. Every capture, good or bad, refills the window with ones, so one frame cannot be detected twice.

The clock frequency, the baud rate and the oversampling factor are parameters. The defaults are a 100 MHz clock, 9600 baud and five samples per bit. The raw line passes through a two-flop synchroniser before it is sampled.

Top module: `uart_os_rx`

## Requirements
- R1: A sample tick occurs once every CLK_HZ/(BAUD*OSR) clock cycles. On each tick, one line sample enters the window.
- R2: Data bits arrive least significant first. With OSR=5, data bit i is read at window position 7+5*i (positions 7 through 42), so a transmitted byte appears unchanged on data_o.
- R3: valid_o is high for exactly one clock cycle per accepted frame.
- R4: A frame whose stop sample (window position 47) is low produces no strobe. In that case data_o keeps the last accepted byte, and data_o changes only in a cycle where valid_o is high.
- R5: A start is recognised only after four consecutive low samples. A low glitch lasting two samples produces no strobe.
- R6: Each frame yields exactly one strobe, including frames sent back to back with no idle time between them.
- R7: While the line is held low continuously, valid_o never asserts.
- R8: Synchronous active-high reset clears valid_o and data_o to 0. After reset, an idle high line produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Raw asynchronous serial line, idle high |
| data_o | output | 8 | Last accepted byte |
| valid_o | output | 1 | One-cycle strobe when a new byte is accepted |

## Verification
The bench sends bytes chosen to expose bit-order and tap errors: alternating patterns, all zeros, all ones, and a single set bit at either end. A wrong tap offset or a reversed shift direction would scramble these bytes.

Frames with a low stop bit check that the block discards them. A design that skips the stop check would strobe on them, or would overwrite the held byte.

A two-sample low glitch checks that a short start run is rejected. Back-to-back frames check that a design which fails to refill the window neither misses the second frame nor strobes twice. A long break checks that a line held low never produces a strobe.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
  // Window position of data bit idx: one full bit past the start run origin,
  // plus half a bit to land near the middle.
  function automatic int tap_pos(input int idx, input int osr);
    return osr + osr / 2 + idx * osr;
  endfunction
endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
  parameter int DIV = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_os_frame.sv
module uart_os_frame
  import uart_os_pkg::*;
#(
  parameter int OSR       = 5,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int RUN  = OSR - 1;
  localparam int STOP = tap_pos(DATA_BITS, OSR);
  localparam int W    = STOP + 1;

  logic [W-1:0]         win_q;
  logic [DATA_BITS-1:0] taps;
  logic                 start_seen;

  for (genvar i = 0; i < DATA_BITS; i++) begin : g_tap
    assign taps[i] = win_q[tap_pos(i, OSR)];
  end

  assign start_seen = (win_q[RUN-1:0] == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q   <= '1;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_seen) begin
        win_q <= '1;
        if (win_q[STOP]) begin
          data_o  <= taps;
          valid_o <= 1'b1;
        end
      end else if (tick_i) begin
        win_q <= {line_i, win_q[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 9600,
  parameter int OSR       = 5,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int DIV = CLK_HZ / (BAUD * OSR);

  logic tick_w;
  logic line_w;

  uart_os_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(rx_i), .sync_o(line_w)
  );

  uart_os_tick #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick_w)
  );

  uart_os_frame #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_frame (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_w), .line_i(line_w),
    .data_o(data_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 9600,
  parameter int OSR       = 5,
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 tick_i,
  input logic                 valid_i,
  input logic [DATA_BITS-1:0] data_i
);
  localparam int DIV = CLK_HZ / (BAUD * OSR);

  int gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || tick_i) gap_q <= 0;
    else                 gap_q <= gap_q + 1;
  end

  // R1: ticks arrive exactly DIV clocks apart
  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |-> (gap_q == DIV - 1));
  a_r1_tick_not_late: assert property (@(posedge clk_i) disable iff (rst_i)
    gap_q < DIV);

  // R3: strobe lasts a single cycle
  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> !valid_i);

  // R4: data only moves together with a strobe
  a_r4_data_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(data_i) |-> valid_i);

  // R8: the cycle after reset shows no strobe and cleared data
  a_r8_reset_clear: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!valid_i && data_i == '0));
endmodule

bind uart_os_rx uart_os_rx_chk #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OSR(OSR), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_w),
  .valid_i(valid_o), .data_i(data_o)
);

// File: tb/sim_uart_os_rx.sv
module sim_uart_os_rx;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int BAUD       = 40_000;
  localparam int OSR        = 5;
  localparam int BIT_CLKS   = CLK_HZ / BAUD;
  localparam int NVEC       = 8;
  // {stop bit, data byte}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h155, 9'h0A3, 9'h100, 9'h1FF, 9'h101, 9'h080, 9'h180, 9'h15A
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [7:0] data;
  logic       valid;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int run    = 0;
  int wide   = 0;
  logic [7:0] last_data = 8'h00;
  logic [7:0] prev_data = 8'h00;

  uart_os_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OSR(OSR), .DATA_BITS(8)) u0 (
    .clk_i(clk), .rst_i(rst), .rx_i(rx), .data_o(data), .valid_o(valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && valid) begin
      pulses    = pulses + 1;
      prev_data = last_data;
      last_data = data;
      run       = run + 1;
      if (run > 1) wide = wide + 1;
    end else begin
      run = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_bits(input logic lvl, input int nbits);
    @(posedge clk);
    rx <= lvl;
    repeat (nbits * BIT_CLKS - 1) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    hold_bits(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_bits(b[i], 1);
    hold_bits(stop, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] exp_data;
    int base;
    exp_data = 8'h00;
    repeat (5) @(posedge clk);
    rst <= 1'b0;
    hold_bits(1'b1, 20);
    @(negedge clk);
    check("R8 valid after reset", int'(valid), 0);
    check("R8 data after reset", int'(data), 0);
    check("R8 idle line strobes", pulses, 0);

    for (int v = 0; v < NVEC; v++) begin
      base = pulses;
      send(VEC[v][7:0], VEC[v][8]);
      hold_bits(1'b1, 3);
      @(negedge clk);
      if (VEC[v][8]) begin
        exp_data = VEC[v][7:0];
        check("R2 strobe count", pulses - base, 1);
        check("R2 byte value", int'(data), int'(exp_data));
      end else begin
        check("R4 bad stop strobe count", pulses - base, 0);
        check("R4 held byte", int'(data), int'(exp_data));
      end
    end

    // R5: two-sample glitch
    base = pulses;
    @(posedge clk);
    rx <= 1'b0;
    repeat (2 * OSR - 1) @(posedge clk);
    hold_bits(1'b1, 20);
    @(negedge clk);
    check("R5 glitch strobe count", pulses - base, 0);

    // R6: back-to-back frames
    base = pulses;
    send(8'h96, 1'b1);
    send(8'h3E, 1'b1);
    hold_bits(1'b1, 3);
    @(negedge clk);
    check("R6 back-to-back count", pulses - base, 2);
    check("R6 first byte", int'(prev_data), 8'h96);
    check("R6 second byte", int'(data), 8'h3E);

    // R7: line held low
    base = pulses;
    hold_bits(1'b0, 80);
    @(negedge clk);
    check("R7 break strobe count", pulses - base, 0);

    // R8: reset recovery, then a normal frame
    @(posedge clk);
    rst <= 1'b1;
    rx  <= 1'b1;
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    check("R8 data cleared", int'(data), 0);
    check("R8 valid cleared", int'(valid), 0);
    hold_bits(1'b1, 12);
    base = pulses;
    send(8'hC3, 1'b1);
    hold_bits(1'b1, 3);
    @(negedge clk);
    check("R8 frame after reset count", pulses - base, 1);
    check("R2 frame after reset byte", int'(data), 8'hC3);

    check("R3 strobe wider than one cycle", wide, 0);
    finish_run();
  end
endmodule